// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a small performance monitoring unit. It holds eight independent 48-bit event counters. Each counter watches one line of a wide event input bus. An 8-bit code picks the line, and the counter adds one on every clock in which that line is high. All state is reached through a simple 32-bit register port: an address, a write enable, write data and a combinational read data return.

Counting for a counter needs two enables: a global run bit and that counter's own enable bit. When a counter steps past its largest value it returns to zero and raises a sticky overflow flag. A level interrupt goes high while any flag is set whose mask bit is 0. Software clears the flags by writing ones to a separate clear register.

The register map is as follows. All addresses are byte addresses.

| Address | Register |
|---|---|
| 0x000 | control, run bit at bit 16 |
| 0x004 | counter enables, bit n for counter n |
| 0x008 | interrupt mask |
| 0x00C | overflow status, read only |
| 0x010 | clear, write-one-to-clear, reads as 0 |
| 0x014 | version, read only |
| 0x020, 0x024 | event select registers |
| 0x100 + 8n | low word of counter n |
| 0x104 + 8n | high word of counter n |

Top module: `evtCounterBank`

## Requirements
- R1: After reset, every counter, the run bit (0x000 bit 16), the enable register (0x004) and the status register (0x00C) read 0. The mask register (0x008) reads 0xFF, both select registers read 0xFFFFFFFF, and irqOut is low.
- R2: A counter adds exactly 1 on each clock edge at which all of the following hold: the run bit is set, its enable bit is set, its select code is not 0xFF, and evtIn[code] is high.
- R3: While the run bit (0x000 bit 16) is clear, no counter changes, whatever its own enable.
- R4: Enable bit n of 0x004 gates counter n only; a counter whose bit is 0 holds its value.
- R5: Counter n takes its code from byte (n mod 4) of the select register at 0x020 + 4*(n/4), that is bits 8*(n mod 4)+7 down to 8*(n mod 4). Code 0xFF never counts, even with evtIn[255] high.
- R6: Counter n reads and writes its bits 31:0 at 0x100+8n. Its bits 47:32 sit in bits 15:0 at 0x104+8n. Bits 31:16 of that high word read as 0, and writes to them are ignored.
- R7: A counter that steps from 2^48-1 wraps to 0 and sets status bit n on the same edge. The bit stays set until it is cleared.
- R8: irqOut is high exactly when some status bit is set whose mask bit is 0; a mask bit of 1 blocks that counter's interrupt.
- R9: A write to 0x010 clears each status bit whose data bit is 1; bits written as 0 leave the status unchanged.
- R10: A register write to a counter in the same cycle as an increment wins. The counter takes the written word, and no overflow is flagged from that cycle.
- R11: A clear write and a new overflow of the same counter in the same cycle leave that status bit set.
- R12: 0x014 reads a fixed version value (default 0x00010100), and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| evtIn | input | 256 | Event pulse lines, sampled each clock |
| irqOut | output | 1 | Level interrupt from unmasked overflow flags |

## Verification
Two pairs of functions can fall in the same cycle, and both are forced on purpose.

The first pair is a software counter write and an event increment. The bench loads a counter with all ones, then writes a new low word while that counter's event line is high. It expects the written word and a status bit that stays clear.

The second pair is a status clear and a fresh overflow. The bench parks a counter at its maximum with its flag already set, then drives the clear write and the wrapping event in one cycle. It expects the flag to survive.

A seeded random phase then mixes writes to counters near the wrap point, clears, masks, enables and select changes with dense random events. Every counter, the status and the interrupt are compared against a cycle model kept in the bench.

// File: rtl/evtBankPkg.sv
package evtBankPkg;
  localparam int NUM_CNT     = 8;
  localparam int CNT_W       = 48;
  localparam int SEL_W       = 8;
  localparam int BUS_W       = 32;
  localparam int ADDR_W      = 12;
  localparam int SEL_PER_REG = BUS_W / SEL_W;
  localparam int NUM_SEL     = NUM_CNT / SEL_PER_REG;
  localparam int HI_W        = CNT_W - BUS_W;
  localparam int CIDX_W      = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int SIDX_W      = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;
  localparam int RUN_BIT     = 16;

  localparam logic [SEL_W-1:0]  SEL_NONE = '1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 12'h000;
  localparam logic [ADDR_W-1:0] ADR_EN   = 12'h004;
  localparam logic [ADDR_W-1:0] ADR_MASK = 12'h008;
  localparam logic [ADDR_W-1:0] ADR_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 12'h010;
  localparam logic [ADDR_W-1:0] ADR_VER  = 12'h014;
  localparam logic [ADDR_W-1:0] ADR_SEL  = 12'h020;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 12'h100;

  // strobes from control to counter datapath
  typedef struct packed {
    logic [NUM_CNT-1:0] wrLo;
    logic [NUM_CNT-1:0] wrHi;
    logic [BUS_W-1:0]   wrData;
    logic [NUM_CNT-1:0] gate;
  } cntCmd_t;
endpackage

// File: rtl/evtBankData.sv
module evtBankData
  import evtBankPkg::*;
#(
  parameter int NUM_EVT = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cntCmd_t                  cmd,
  input  logic [NUM_CNT*SEL_W-1:0] selFlat,
  input  logic [NUM_EVT-1:0]       evtIn,
  output logic [NUM_CNT*CNT_W-1:0] cntFlat,
  output logic [NUM_CNT-1:0]       ovfPulse
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    logic [SEL_W-1:0] code;
    logic [CNT_W-1:0] cnt;
    logic             hit;
    logic             bump;
    logic             swWr;

    assign code = selFlat[g*SEL_W +: SEL_W];
    assign hit  = (int'(code) < NUM_EVT) ? evtIn[code] : 1'b0;
    assign bump = cmd.gate[g] && (code != SEL_NONE) && hit;
    assign swWr = cmd.wrLo[g] || cmd.wrHi[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (cmd.wrLo[g]) begin
        cnt[BUS_W-1:0] <= cmd.wrData;
      end else if (cmd.wrHi[g]) begin
        cnt[CNT_W-1:BUS_W] <= cmd.wrData[HI_W-1:0];
      end else if (bump) begin
        cnt <= cnt + 1'b1;
      end
    end

    // wrap occurs only from a real increment, never on a write cycle
    assign ovfPulse[g] = bump && !swWr && (&cnt);
    assign cntFlat[g*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/evtBankCtrl.sv
module evtBankCtrl
  import evtBankPkg::*;
#(
  parameter logic [BUS_W-1:0] VERSION = 32'h0001_0100
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWrEn,
  input  logic [BUS_W-1:0]         regWrData,
  output logic [BUS_W-1:0]         regRdData,
  input  logic [NUM_CNT*CNT_W-1:0] cntFlat,
  input  logic [NUM_CNT-1:0]       ovfPulse,
  output cntCmd_t                  cmd,
  output logic [NUM_CNT*SEL_W-1:0] selFlat,
  output logic [NUM_CNT-1:0]       intStatus,
  output logic [NUM_CNT-1:0]       intMask,
  output logic                     globalEn
);
  logic [NUM_CNT-1:0] cntEn;
  logic [BUS_W-1:0]   selReg [NUM_SEL];
  logic [CNT_W-1:0]   cntArr [NUM_CNT];

  logic              hitCnt, slotOk, hitSel, selOk;
  logic [4:0]        slot;
  logic [CIDX_W-1:0] slotIdx;
  logic [1:0]        selIdx;
  logic [NUM_CNT-1:0] clrBits;

  assign hitCnt  = regAddr[ADDR_W-1:8] == ADR_CNT[ADDR_W-1:8];
  assign slot    = regAddr[7:3];
  assign slotOk  = int'(slot) < NUM_CNT;
  assign slotIdx = slot[CIDX_W-1:0];
  assign hitSel  = (regAddr[ADDR_W-1:4] == ADR_SEL[ADDR_W-1:4]) && (regAddr[1:0] == 2'b00);
  assign selIdx  = regAddr[3:2];
  assign selOk   = int'(selIdx) < NUM_SEL;
  assign clrBits = (regWrEn && regAddr == ADR_CLR) ? regWrData[NUM_CNT-1:0] : '0;

  for (genvar g = 0; g < NUM_CNT; g++) begin : gStrobe
    assign cmd.wrLo[g] = regWrEn && hitCnt && (int'(slot) == g) && !regAddr[2];
    assign cmd.wrHi[g] = regWrEn && hitCnt && (int'(slot) == g) &&  regAddr[2];
    assign cntArr[g]   = cntFlat[g*CNT_W +: CNT_W];
  end
  assign cmd.wrData = regWrData;
  assign cmd.gate   = globalEn ? cntEn : '0;

  for (genvar k = 0; k < NUM_SEL; k++) begin : gSelOut
    assign selFlat[k*BUS_W +: BUS_W] = selReg[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      cntEn     <= '0;
      intMask   <= '1;
      intStatus <= '0;
      for (int k = 0; k < NUM_SEL; k++) selReg[k] <= '1;
    end else begin
      intStatus <= (intStatus & ~clrBits) | ovfPulse;
      if (regWrEn) begin
        if (regAddr == ADR_CTRL) globalEn <= regWrData[RUN_BIT];
        if (regAddr == ADR_EN)   cntEn    <= regWrData[NUM_CNT-1:0];
        if (regAddr == ADR_MASK) intMask  <= regWrData[NUM_CNT-1:0];
        for (int k = 0; k < NUM_SEL; k++) begin
          if (hitSel && selOk && int'(selIdx) == k) selReg[k] <= regWrData;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (hitCnt) begin
      if (slotOk) begin
        regRdData = regAddr[2] ? BUS_W'(cntArr[slotIdx][CNT_W-1:BUS_W])
                               : cntArr[slotIdx][BUS_W-1:0];
      end
    end else if (hitSel) begin
      if (selOk) regRdData = selReg[selIdx[SIDX_W-1:0]];
    end else begin
      case (regAddr)
        ADR_CTRL: regRdData[RUN_BIT] = globalEn;
        ADR_EN:   regRdData[NUM_CNT-1:0] = cntEn;
        ADR_MASK: regRdData[NUM_CNT-1:0] = intMask;
        ADR_STAT: regRdData[NUM_CNT-1:0] = intStatus;
        ADR_VER:  regRdData = VERSION;
        default:  regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/evtCounterBank.sv
module evtCounterBank
  import evtBankPkg::*;
#(
  parameter int                NUM_EVT = 256,
  parameter logic [BUS_W-1:0]  VERSION = 32'h0001_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic              irqOut
);
  cntCmd_t                  cmd;
  logic [NUM_CNT*SEL_W-1:0] selFlat;
  logic [NUM_CNT*CNT_W-1:0] cntFlat;
  logic [NUM_CNT-1:0]       ovfPulse;
  logic [NUM_CNT-1:0]       intStatus;
  logic [NUM_CNT-1:0]       intMask;
  logic                     globalEn;

  evtBankCtrl #(.VERSION(VERSION)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cntFlat(cntFlat),
    .ovfPulse(ovfPulse), .cmd(cmd), .selFlat(selFlat),
    .intStatus(intStatus), .intMask(intMask), .globalEn(globalEn)
  );

  evtBankData #(.NUM_EVT(NUM_EVT)) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .selFlat(selFlat),
    .evtIn(evtIn), .cntFlat(cntFlat), .ovfPulse(ovfPulse)
  );

  assign irqOut = |(intStatus & ~intMask);
endmodule

// File: rtl/evtBankChk.sv
module evtBankChk
  import evtBankPkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [ADDR_W-1:0]        regAddr,
  input logic                     regWrEn,
  input logic [NUM_CNT*CNT_W-1:0] cntFlat,
  input logic [NUM_CNT-1:0]       intStatus,
  input logic [NUM_CNT-1:0]       intMask,
  input logic                     irqOut,
  input logic                     globalEn
);
  logic             cntWrite;
  logic             clrWrite;
  logic [CNT_W-1:0] cnt0;

  assign cntWrite = regWrEn && (regAddr[ADDR_W-1:8] == ADR_CNT[ADDR_W-1:8]);
  assign clrWrite = regWrEn && (regAddr == ADR_CLR);
  assign cnt0     = cntFlat[CNT_W-1:0];

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn && !cntWrite) |=> $stable(cntFlat)); // R3

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrite |=> (cnt0 == $past(cnt0) || cnt0 == CNT_W'($past(cnt0) + 1'b1))); // R2

  AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ((&cnt0) && !cntWrite) ##1 (cnt0 == '0) |-> intStatus[0]); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clrWrite |=> ((intStatus & $past(intStatus)) == $past(intStatus))); // R9

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&intMask) |-> !irqOut); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|intStatus)); // R8
endmodule

bind evtCounterBank evtBankChk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .cntFlat(cntFlat), .intStatus(intStatus), .intMask(intMask),
  .irqOut(irqOut), .globalEn(globalEn)
);

// File: tb/evtCounterBank_tb.sv
module evtCounterBank_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [11:0]  regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic [255:0] evtIn = '0;
  logic         irqOut;

  int nChecks = 0;
  int nBad = 0;
  bit done = 0;

  // bench model
  logic [47:0] mCnt [8];
  logic [7:0]  mSel [8];
  logic [7:0]  mSts, mMask, mEn;
  logic        mGlob;

  evtCounterBank u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtIn(evtIn), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] loAdr(int n);
    return 12'(12'h100 + n*8);
  endfunction

  function automatic logic expIrq();
    return |(mSts & ~mMask);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    regWrEn = 1'b0;
    regAddr = a;
    #1;
    chk(tag, {32'h0, regRdData}, {32'h0, exp});
  endtask

  // one clock: drive at negedge, advance model, return at next negedge
  task automatic tick(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [255:0] ev);
    logic [7:0] ovf;
    logic [7:0] clr;
    regWrEn = we; regAddr = a; regWrData = d; evtIn = ev;
    ovf = '0;
    for (int n = 0; n < 8; n++) begin
      logic inc;
      inc = mGlob && mEn[n] && (mSel[n] != 8'hFF) && ev[mSel[n]];
      if (we && a == loAdr(n)) mCnt[n][31:0] = d;
      else if (we && a == 12'(loAdr(n) + 4)) mCnt[n][47:32] = d[15:0];
      else if (inc) begin
        if (&mCnt[n]) begin mCnt[n] = '0; ovf[n] = 1'b1; end
        else mCnt[n] = mCnt[n] + 1;
      end
    end
    clr = (we && a == 12'h010) ? d[7:0] : 8'h00;
    mSts = (mSts & ~clr) | ovf;
    if (we) begin
      case (a)
        12'h000: mGlob = d[16];
        12'h004: mEn = d[7:0];
        12'h008: mMask = d[7:0];
        12'h020: for (int k = 0; k < 4; k++) mSel[k] = d[8*k +: 8];
        12'h024: for (int k = 0; k < 4; k++) mSel[k+4] = d[8*k +: 8];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    evtIn = '0;
  endtask

  task automatic checkAll(input string tag);
    for (int n = 0; n < 8; n++) begin
      rdChk({tag, " cnt lo"}, loAdr(n), mCnt[n][31:0]);
      rdChk({tag, " cnt hi"}, 12'(loAdr(n) + 4), {16'h0, mCnt[n][47:32]});
    end
    rdChk({tag, " status"}, 12'h00C, {24'h0, mSts});
    chk({tag, " irq"}, {63'h0, irqOut}, {63'h0, expIrq()});
  endtask

  function automatic logic [255:0] rndEv();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom() & $urandom();
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [255:0] ev;
    void'($urandom(32'h5EED1234));
    for (int n = 0; n < 8; n++) begin mCnt[n] = '0; mSel[n] = 8'hFF; end
    mSts = 0; mMask = 8'hFF; mEn = 0; mGlob = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 ctrl", 12'h000, 32'h0);
    rdChk("R1 enable", 12'h004, 32'h0);
    rdChk("R1 mask", 12'h008, 32'hFF);
    rdChk("R1 status", 12'h00C, 32'h0);
    rdChk("R1 sel0", 12'h020, 32'hFFFF_FFFF);
    rdChk("R1 sel1", 12'h024, 32'hFFFF_FFFF);
    chk("R1 irq", {63'h0, irqOut}, 64'h0);
    checkAll("R1");

    // R12 version read only
    rdChk("R12 version", 12'h014, 32'h0001_0100);
    tick(1, 12'h014, 32'hDEAD_BEEF, '0);
    rdChk("R12 version after write", 12'h014, 32'h0001_0100);

    // R5 selects: counters 0..3 codes 0..3, 4->0x10, 5->0x20, 6->0xFF, 7->0x80
    tick(1, 12'h020, 32'h0302_0100, '0);
    tick(1, 12'h024, 32'h80FF_2010, '0);
    rdChk("R5 sel0 readback", 12'h020, 32'h0302_0100);
    rdChk("R5 sel1 readback", 12'h024, 32'h80FF_2010);
    tick(1, 12'h004, 32'hFF, '0);

    // R3 run bit clear: nothing counts
    for (int i = 0; i < 20; i++) tick(0, 12'h0, 32'h0, '1);
    checkAll("R3 stopped");

    // R2 R4 R5 run with some counters disabled
    tick(1, 12'h000, 32'h0001_0000, '0);
    rdChk("R2 run bit", 12'h000, 32'h0001_0000);
    tick(1, 12'h004, 32'hF5, '0);
    for (int i = 0; i < 200; i++) tick(0, 12'h0, 32'h0, rndEv() | (256'h1 << 255));
    checkAll("R2 R4 counting");
    chk("R4 disabled counter1 held", {16'h0, mCnt[1]}, 64'h0);
    rdChk("R5 code FF never counts", loAdr(6), 32'h0);
    for (int i = 0; i < 5; i++) tick(0, 12'h0, 32'h0, 256'h1);
    checkAll("R2 steady pulses");

    // R6 high word
    tick(1, 12'h10C + 12'h8, 32'hABCD_1234, '0); // counter 2 high
    rdChk("R6 high word upper bits zero", 12'h114, 32'h0000_1234);
    tick(1, 12'h004, 32'hFF, '0);

    // R7 R8 wrap of counter 1 (code 1), masked first
    tick(1, 12'h10C, 32'h0000_FFFF, '0);
    tick(1, 12'h108, 32'hFFFF_FFFE, '0);
    tick(0, 12'h0, 32'h0, 256'h2);
    rdChk("R7 at max lo", 12'h108, 32'hFFFF_FFFF);
    tick(0, 12'h0, 32'h0, 256'h2);
    rdChk("R7 wrapped lo", 12'h108, 32'h0);
    rdChk("R7 wrapped hi", 12'h10C, 32'h0);
    chk("R7 status bit1", {56'h0, mSts}, 64'h2);
    rdChk("R7 status reg", 12'h00C, {24'h0, mSts});
    chk("R8 masked irq low", {63'h0, irqOut}, 64'h0);
    tick(1, 12'h008, 32'hFD, '0);
    chk("R8 unmasked irq high", {63'h0, irqOut}, 64'h1);
    for (int i = 0; i < 3; i++) tick(0, 12'h0, 32'h0, '0);
    rdChk("R7 sticky status", 12'h00C, 32'h2);

    // R9 clear
    tick(1, 12'h010, 32'h0, '0);
    rdChk("R9 zero clear no effect", 12'h00C, 32'h2);
    tick(1, 12'h010, 32'h2, '0);
    rdChk("R9 clear bit1", 12'h00C, 32'h0);
    chk("R9 irq drops", {63'h0, irqOut}, 64'h0);
    rdChk("R9 clear reads zero", 12'h010, 32'h0);

    // R10 write beats increment at wrap point, counter 0
    tick(1, 12'h104, 32'h0000_FFFF, '0);
    tick(1, 12'h100, 32'hFFFF_FFFF, '0);
    tick(1, 12'h100, 32'h0000_0005, 256'h1);
    rdChk("R10 written value wins", 12'h100, 32'h5);
    rdChk("R10 no overflow flagged", 12'h00C, 32'h0);

    // R11 clear with simultaneous overflow, counter 3
    tick(1, 12'h11C, 32'h0000_FFFF, '0);
    tick(1, 12'h118, 32'hFFFF_FFFF, '0);
    tick(0, 12'h0, 32'h0, 256'h8);
    rdChk("R11 first wrap flag", 12'h00C, 32'h8);
    tick(1, 12'h11C, 32'h0000_FFFF, '0);
    tick(1, 12'h118, 32'hFFFF_FFFF, '0);
    tick(1, 12'h010, 32'h8, 256'h8);
    rdChk("R11 flag survives clear", 12'h00C, 32'h8);
    checkAll("R11 state");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      int n;
      op = $urandom_range(0, 19);
      n  = $urandom_range(0, 7);
      ev = rndEv();
      case (op)
        0: tick(1, 12'h004, $urandom(), ev);
        1: tick(1, 12'h008, $urandom(), ev);
        2: tick(1, 12'h010, $urandom(), ev);
        3: tick(1, 12'h000, ($urandom_range(0, 3) != 0) ? 32'h0001_0000 : 32'h0, ev);
        4: tick(1, 12'h020 + 12'(4 * $urandom_range(0, 1)),
                ($urandom_range(0, 1) != 0) ? $urandom() : (32'hFF << (8 * $urandom_range(0, 3))) | $urandom_range(0, 255),
                ev);
        5: tick(1, 12'(loAdr(n) + 4), {$urandom_range(0, 65535), 16'hFFFF}, ev);
        6: tick(1, loAdr(n), 32'hFFFF_FFF0 | $urandom_range(0, 15), ev);
        7: tick(1, loAdr(n), $urandom(), ev);
        default: tick(0, 12'h0, 32'h0, ev);
      endcase
      if (i % 50 == 49) checkAll("R2 R7 R8 R9 random");
      else begin
        rdChk("R7 R9 random status", 12'h00C, {24'h0, mSts});
        chk("R8 random irq", {63'h0, irqOut}, {63'h0, expIrq()});
      end
    end
    checkAll("R10 R11 final");

    done = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule